// File: doc/BRIEF.md
# Regulator Pin Fault Supervisor

This block supervises the output pin of an auxiliary regulator inside a switching power controller. It watches a supply-ready flag, two comparator flags that report whether the regulator pin sits below a low threshold (14 V) or above a high threshold (15 V), and the low-side PWM pulse. Once per power-up it makes a single startup check of the pin, a fixed 10 µs after supply-ready rises. A pin still below the low threshold at that moment means the pin capacitor is missing or too small, or the pin is open. Switching is then never allowed, and the block asks for one undervoltage-lockout (UVLO) restart of the supply.

When the check passes, the block raises the PWM enable. From then on it samples the over-voltage comparator once per low-side pulse, at the pulse's falling edge. Three pulses in a row that show over-voltage trip the protection. The trip removes the PWM enable and requests one UVLO restart.

A fault-cause register records which protection caused the most recent restart. There is no data stream at the edge of this block. All pins are plain level or pulse controls, so no valid/ready back-pressure rules apply. The comparator and PWM inputs are assumed to be synchronous to the clock.

Top module: `regpin_fault_sup`

## Requirements
- R1: While reset is asserted and just after it is released, pwm_en is 0, uvlo_req is 0 and fault_cause is 2'b00.
- R2: The startup check samples reg_below_lo only at the clock edge exactly DELAY_CYC cycles (10 µs, which is 500 cycles at 50 MHz) after the first edge that sees supply_ok high. reg_below_lo at any other cycle of that wait has no effect on pwm_en or uvlo_req.
- R3: If reg_below_lo is 1 at the startup sample, pwm_en stays 0 for the rest of that power-up. uvlo_req is 1 in the cycle after the sample, and fault_cause becomes 2'b01 (pin fault).
- R4: If reg_below_lo is 0 at the startup sample, pwm_en is 1 from the cycle after the sample. It stays 1 until a trip or a supply drop, and it is never 1 before a passing sample.
- R5: While pwm_en is 1, reg_above_hi is sampled on each falling edge of pwm_lo, meaning the edge where pwm_lo goes from 1 to 0. The third consecutive sample at 1 makes, in the next cycle, pwm_en 0, uvlo_req 1 and fault_cause 2'b10 (over-voltage). Pulses before the check passes or after a fault are ignored.
- R6: A falling edge of pwm_lo with reg_above_hi at 0 clears the consecutive count. After that, three fresh consecutive over-voltage pulses are needed to trip.
- R7: supply_ok at 0 returns the block to idle in the next cycle with pwm_en 0, and clears the delay and over-voltage counters. The next rise of supply_ok repeats the startup check, and no uvlo_req is issued for the drop.
- R8: uvlo_req is a single-cycle pulse for each fault. After a fault, pwm_en stays 0 until supply_ok falls and rises again and a new startup check passes.
- R9: fault_cause changes only in the cycle in which uvlo_req is 1, and only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above its turn-on threshold |
| reg_below_lo | input | 1 | Comparator: regulator pin below 14 V |
| reg_above_hi | input | 1 | Comparator: regulator pin above 15 V |
| pwm_lo | input | 1 | Low-side PWM pulse |
| pwm_en | output | 1 | PWM switching permitted |
| uvlo_req | output | 1 | One-cycle request for a UVLO restart cycle |
| fault_cause | output | 2 | Last restart cause: 00 none, 01 pin fault, 10 over-voltage |

## Verification
The hardest case to reach from the ports is the single startup sample instant. The comparator must be shown to count only on that one edge out of 500, so the stimulus toggles reg_below_lo randomly on every other cycle of the wait and sets the intended value only for the sampling edge.

The second hard case is the over-voltage run. A trip needs three aligned pulse falling edges with nothing clean in between. Random over-voltage patterns are therefore mixed with directed runs that are broken after two pulses, either by a clean pulse or by a supply drop, before a third over-voltage pulse is applied.

// File: rtl/regpin_pkg.sv
package regpin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } sup_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_PIN  = 2'b01,
    CAUSE_OV   = 2'b10
  } cause_t;
endpackage

// File: rtl/regpin_delay.sv
module regpin_delay
  import regpin_pkg::*;
  #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  // one history flop per watched signal
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/regpin_dly_timer.sv
module regpin_dly_timer #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end

  // R2: the count never passes the terminal value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R7: leaving the wait clears the count
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);
endmodule

// File: rtl/regpin_ov_run.sv
module regpin_ov_run #(
  parameter int RUN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pulse_end,
  input  logic ov,
  output logic trip
);
  localparam int W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [W-1:0] LAST = W'(RUN_LEN - 1);

  logic [W-1:0] cnt;

  assign trip = enable && pulse_end && ov && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!enable)    cnt <= '0;
    else if (pulse_end) begin
      if (!ov || trip)   cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end

  // R5: the run count stays below the trip length
  p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R6: a clean pulse end empties the run
  p_run_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pulse_end && !ov) |=> cnt == '0);
  // R5: the count holds between pulse ends
  p_run_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pulse_end) |=> $stable(cnt));
endmodule

// File: rtl/regpin_fault_sup.sv
module regpin_fault_sup
  import regpin_pkg::*;
  #(
  parameter int CLK_HZ          = 50_000_000,
  parameter int SAMPLE_DELAY_NS = 10_000,
  parameter int OV_RUN_LEN      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       reg_below_lo,
  input  logic       reg_above_hi,
  input  logic       pwm_lo,
  output logic       pwm_en,
  output logic       uvlo_req,
  output logic [1:0] fault_cause
);
  localparam int DELAY_CYC = (CLK_HZ / 1000) * SAMPLE_DELAY_NS / 1_000_000;

  sup_state_t state, nxt;
  logic [1:0] hist;
  logic       sup_rise, pwm_fall, tmr_done, ov_trip, enter_fault;
  cause_t     nxt_cause;

  regpin_delay #(.N(2)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .d({pwm_lo, supply_ok}), .q(hist)
  );

  assign sup_rise = supply_ok & ~hist[0];
  assign pwm_fall = hist[1] & ~pwm_lo;

  regpin_dly_timer #(.LIMIT(DELAY_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .run(state == ST_WAIT), .done(tmr_done)
  );

  regpin_ov_run #(.RUN_LEN(OV_RUN_LEN)) u_ov (
    .clk(clk), .rst_n(rst_n),
    .enable(state == ST_RUN), .pulse_end(pwm_fall),
    .ov(reg_above_hi), .trip(ov_trip)
  );

  always_comb begin
    nxt         = state;
    enter_fault = 1'b0;
    nxt_cause   = CAUSE_NONE;
    if (!supply_ok) begin
      nxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (sup_rise) nxt = ST_WAIT;
        ST_WAIT: if (tmr_done) begin
          if (reg_below_lo) begin
            nxt = ST_FAULT; enter_fault = 1'b1; nxt_cause = CAUSE_PIN;
          end else begin
            nxt = ST_RUN;
          end
        end
        ST_RUN: if (ov_trip) begin
          nxt = ST_FAULT; enter_fault = 1'b1; nxt_cause = CAUSE_OV;
        end
        ST_FAULT: nxt = ST_FAULT;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      pwm_en      <= 1'b0;
      uvlo_req    <= 1'b0;
      fault_cause <= CAUSE_NONE;
    end else begin
      state    <= nxt;
      pwm_en   <= (nxt == ST_RUN);
      uvlo_req <= enter_fault;
      if (enter_fault) fault_cause <= nxt_cause;
    end
  end

  // R8: restart request lasts one cycle
  p_uvlo_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_req |=> !uvlo_req);
  // R3: a restart request never coexists with switching
  p_uvlo_no_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_req |-> !pwm_en);
  // R7: a supply drop removes switching next cycle
  p_drop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !pwm_en && !uvlo_req);
  // R4: enable only rises after a clean sample while the supply is up
  p_en_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> $past(supply_ok) && !$past(reg_below_lo));
  // R9: cause moves only alongside a restart request
  p_cause_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_req |-> $stable(fault_cause));
  // R8: once faulted, enable stays off while the supply stays up
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && supply_ok) |=> !pwm_en);
endmodule

// File: tb/sim_regpin_fault_sup.sv
module sim_regpin_fault_sup;
  localparam int D = 500;  // 10 us at 20 ns

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 0, reg_below_lo = 0, reg_above_hi = 0, pwm_lo = 0;
  logic pwm_en, uvlo_req;
  logic [1:0] fault_cause;

  int checks = 0, fails = 0;
  int run_len = 0;
  bit tripped = 0, passed = 0, done = 0;
  logic [1:0] exp_cause = 2'b00;

  always #10 clk = ~clk;

  regpin_fault_sup u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .reg_below_lo(reg_below_lo), .reg_above_hi(reg_above_hi),
    .pwm_lo(pwm_lo), .pwm_en(pwm_en), .uvlo_req(uvlo_req),
    .fault_cause(fault_cause)
  );

  function automatic bit trips_now(int run);
    return run == 3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic power_up(input bit bad);
    @(negedge clk); supply_ok = 1; reg_below_lo = 1'($urandom);
    for (int k = 1; k <= D; k++) begin
      @(negedge clk);
      reg_below_lo = (k == D) ? bad : 1'($urandom);
      if (k == D / 2) chk(pwm_en == 0 && uvlo_req == 0, "R2 mid-wait quiet", pwm_en, 0);
    end
    @(negedge clk);
    reg_below_lo = 1'($urandom);
    chk(pwm_en == !bad, bad ? "R3 enable after bad sample" : "R4 enable after good sample", pwm_en, !bad);
    chk(uvlo_req == bad, "R3 restart request at sample", uvlo_req, bad);
    if (bad) exp_cause = 2'b01;
    chk(fault_cause == exp_cause, "R3 cause after sample", fault_cause, exp_cause);
    @(negedge clk);
    chk(uvlo_req == 0, "R8 single cycle request", uvlo_req, 0);
    passed = !bad; tripped = bad; run_len = 0;
  endtask

  task automatic pulse(input bit ov);
    bit trip;
    @(negedge clk); pwm_lo = 1; reg_above_hi = 1'($urandom);
    @(negedge clk); pwm_lo = 0; reg_above_hi = ov;
    @(negedge clk); reg_above_hi = 1'($urandom);
    trip = 0;
    if (passed && !tripped) begin
      run_len = ov ? run_len + 1 : 0;
      trip = trips_now(run_len);
      if (trip) begin tripped = 1; exp_cause = 2'b10; end
    end
    chk(uvlo_req == trip, "R5 trip request on pulse", uvlo_req, trip);
    chk(pwm_en == (passed && !tripped), "R5 enable after pulse", pwm_en, passed && !tripped);
    chk(fault_cause == exp_cause, "R9 cause after pulse", fault_cause, exp_cause);
  endtask

  task automatic power_down();
    @(negedge clk); supply_ok = 0;
    @(negedge clk);
    chk(pwm_en == 0 && uvlo_req == 0, "R7 drop to idle", pwm_en, 0);
    chk(fault_cause == exp_cause, "R9 cause kept over drop", fault_cause, exp_cause);
    passed = 0; tripped = 0; run_len = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(pwm_en == 0 && uvlo_req == 0 && fault_cause == 0, "R1 in reset", fault_cause, 0);
    rst_n = 1;
    @(negedge clk);
    chk(pwm_en == 0 && uvlo_req == 0 && fault_cause == 0, "R1 after reset", fault_cause, 0);

    // pulses before any startup check are ignored (R5)
    pulse(1); pulse(1); pulse(1);

    // good start, broken run then trip (R4 R5 R6)
    power_up(0);
    pulse(1); pulse(1); pulse(0); pulse(1); pulse(1);
    chk(pwm_en == 1, "R6 run restarted after clean pulse", pwm_en, 1);
    pulse(1);
    pulse(1); pulse(1); pulse(1);  // after fault: ignored (R8)
    power_down();

    // bad start, pulses ignored, cause held (R3 R8 R9)
    power_up(1);
    pulse(1); pulse(1); pulse(1);
    power_down();

    // run interrupted by supply drop clears the count (R7)
    power_up(0);
    pulse(1); pulse(1);
    power_down();
    power_up(0);
    pulse(1);
    chk(pwm_en == 1, "R7 count cleared by drop", pwm_en, 1);
    power_down();

    // random power cycles
    for (int c = 0; c < 14; c++) begin
      power_up(($urandom % 4) == 0);
      for (int p = 0; p < 10; p++) pulse(1'($urandom));
      power_down();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule